// File: doc/BRIEF.md
# RC Oscillator Frequency Tuning Loop

This block keeps an on-chip RC oscillator on frequency by trimming its 8-bit tuning code in a closed loop. It runs on the RC clock. A slow reference clock of about 32 kHz comes in through a two-flop synchronizer. Each rising reference edge closes one measurement window. The number of RC clock cycles in that window is compared against a programmable 12-bit target. The code steps down when the oscillator runs fast and up when it runs slow. An asymmetric dead band around the target, set by two 4-bit hysteresis values, suppresses steps near the target. An invert control swaps the step direction for oscillators whose frequency falls as the code rises.

The loop has several controls:
- A run control stops the loop and resets it, which reloads the programmed code as the starting point.
- An update control freezes the code while measurements continue.
- A bypass control drives the programmed code straight to the oscillator.

The block also divides the RC clock down to a nominal 1 MHz output. The divide ratio is either a programmable ratio (corrected) or a fixed ratio (uncorrected). It also keeps a sticky error flag that is raised when a whole divider period does not fit inside one reference period.

Top module: `rc_trim_loop`

## Requirements
- R1: While reset is asserted, `code_now`, `cnt_last`, `mhz_err` and `mhz_clk` are all 0, given `use_prog`=0 and `mhz_en`=0.
- R2: A rising edge of `ref_clk` acts at the third rising edge of `rc_clk` after it, because of the two-flop synchronizer plus the edge register. While running, each such edge after the first captures into `cnt_last` the number of `rc_clk` cycles between it and the previous edge, saturating at 4095.
- R3: At each captured window with `tune_upd`=1, the loop compares the count with the target. If the count is above `target_cnt + hyst_hi`, the code decreases by one. If the count is below `target_cnt - hyst_lo`, the code increases by one. Otherwise the code holds. With `step_flip`=1 both directions are swapped.
- R4: The tuning code saturates at 0x00 and 0xFF and never wraps.
- R5: While `tune_run`=0, the tuning code is reloaded from `prog_code` on every clock and `cnt_last` keeps its value. After `tune_run` rises, the first reference edge only opens a window and captures nothing.
- R6: With `tune_update`=0 the tuning code holds, while `cnt_last` keeps capturing new windows.
- R7: With `use_prog`=1, `code_now` equals `prog_code`. The loop keeps tracking underneath, and its code appears on `code_now` when `use_prog` returns to 0.
- R8: The derived clock has period N cycles and is high for the first floor(N/2) cycles of each period. It restarts at every reference edge and is 0 whenever `mhz_en`=0.
  - N is `mhz_target` (values below 2 treated as 2) when `mhz_sel`=1.
  - N is the fixed ratio RAW_DIV (24) when `mhz_sel`=0.
- R9: With `mhz_en`=1, `mhz_err` is set at a reference edge when a previous edge has been seen and no full divider period completed between them, that is, when the window is N cycles or shorter. It stays set until `err_clr`=1, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | RC oscillator clock, clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous |
| tune_run | input | 1 | Run the loop; 0 stops and resets it |
| tune_upd | input | 1 | Allow the code to change |
| use_prog | input | 1 | Bypass: drive the programmed code out |
| step_flip | input | 1 | Swap the step direction |
| prog_code | input | 8 | Programmed tuning code |
| hyst_hi | input | 4 | Dead band above the target |
| hyst_lo | input | 4 | Dead band below the target |
| target_cnt | input | 12 | Target RC cycles per reference period |
| mhz_en | input | 1 | Enable the derived clock |
| mhz_sel | input | 1 | 1 = programmable ratio, 0 = fixed ratio |
| mhz_target | input | 12 | Programmable divide ratio |
| err_clr | input | 1 | Clear the error flag |
| code_now | output | 8 | Tuning code in use |
| cnt_last | output | 12 | Last captured window count |
| mhz_clk | output | 1 | Derived clock |
| mhz_err | output | 1 | Sticky divider error flag |

## Verification
The step logic is driven with window lengths well above the target, exactly on both band limits, one cycle beyond the lower limit, and below the target. These patterns separate correct band edges from off-by-one comparisons and also separate the two hysteresis inputs from each other. The same lengths are repeated with invert set, and with starting codes at 0xFE and 0x01, which exposes swapped directions and wrap-around. The error flag is driven with windows longer and shorter than the fixed ratio, so that a flag which never sets, never holds or never clears is caught. The derived clock is sampled with a large ratio, a clamped ratio and the enable off. An overlong window shows whether the count saturates.

// File: rtl/rc_trim_pkg.sv
package rc_trim_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Direction decision for one captured window.
  function automatic step_e judge(input int cnt, input int tgt, input int hh,
                                  input int hl, input logic flip);
    step_e s;
    s = STEP_HOLD;
    if (cnt > tgt + hh)      s = STEP_DOWN;
    else if (cnt < tgt - hl) s = STEP_UP;
    if (flip) begin
      if (s == STEP_UP)        s = STEP_DOWN;
      else if (s == STEP_DOWN) s = STEP_UP;
    end
    return s;
  endfunction

  // Saturating single step of the code.
  function automatic int apply_step(input int code, input step_e s, input int top);
    if (s == STEP_UP   && code < top) return code + 1;
    if (s == STEP_DOWN && code > 0)   return code - 1;
    return code;
  endfunction

  // Effective divide ratio of the derived clock.
  function automatic int div_len(input logic sel, input int tgt, input int raw);
    if (!sel) return raw;
    return (tgt < 2) ? 2 : tgt;
  endfunction

endpackage

// File: rtl/rc_ref_sync.sv
module rc_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic edge_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], ref_in};
  end

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its delayed copy
  assign edge_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rc_window_counter.sv
module rc_window_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             edge_i,
  output logic [CNT_W-1:0] meas_cnt,
  output logic             meas_vld,
  output logic [CNT_W-1:0] last_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] win;
  logic             primed;

  assign meas_cnt = win;
  assign meas_vld = run & edge_i & primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win      <= '0;
      primed   <= 1'b0;
      last_cnt <= '0;
    end else if (!run) begin
      win    <= '0;
      primed <= 1'b0;
    end else if (edge_i) begin
      if (primed) last_cnt <= win;
      primed <= 1'b1;
      win    <= CNT_W'(1);
    end else if (win != CNT_MAX) begin
      win <= win + 1'b1;
    end
  end
endmodule

// File: rtl/rc_code_stepper.sv
module rc_code_stepper
  import rc_trim_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 12,
  parameter int HYS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              upd,
  input  logic              flip,
  input  logic [CODE_W-1:0] prog,
  input  logic [CNT_W-1:0]  tgt,
  input  logic [HYS_W-1:0]  hh,
  input  logic [HYS_W-1:0]  hl,
  input  logic              meas_vld,
  input  logic [CNT_W-1:0]  meas_cnt,
  output logic [CODE_W-1:0] calc
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  step_e dir;
  always_comb dir = judge(int'(meas_cnt), int'(tgt), int'(hh), int'(hl), flip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                calc <= '0;
    else if (!run)             calc <= prog;
    else if (meas_vld && upd)  calc <= CODE_W'(apply_step(int'(calc), dir, CODE_MAX));
  end

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> (calc == $past(calc) || calc == $past(calc) + 1'b1 ||
                           calc == $past(calc) - 1'b1)); // R3
  AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && ($past(calc) == '1) |-> calc != '0); // R4
  AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && ($past(calc) == '0) |-> calc != '1); // R4
  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && !$past(upd) |-> $stable(calc)); // R6
endmodule

// File: rtl/rc_mhz_div.sv
module rc_mhz_div
  import rc_trim_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int RAW_DIV = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             en,
  input  logic             sel,
  input  logic [CNT_W-1:0] tgt,
  input  logic             err_clr,
  output logic             mhz_clk,
  output logic             err
);
  logic [CNT_W-1:0] div_cnt;
  logic             hit;
  logic             seen;
  logic             err_set;
  int               n;

  always_comb n = div_len(sel, int'(tgt), RAW_DIV);

  assign err_set = edge_i & seen & en & ~hit;
  assign mhz_clk = en & (int'(div_cnt) < n / 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      hit     <= 1'b0;
      seen    <= 1'b0;
    end else if (edge_i) begin
      div_cnt <= '0;
      hit     <= 1'b0;
      seen    <= 1'b1;
    end else if (int'(div_cnt) >= n - 1) begin
      div_cnt <= '0;
      hit     <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (err_set) err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err) && !$past(err_clr) |-> err); // R9
  AST_ERR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(edge_i)); // R9
endmodule

// File: rtl/rc_trim_loop.sv
module rc_trim_loop #(
  parameter int CODE_W      = 8,
  parameter int CNT_W       = 12,
  parameter int HYS_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RAW_DIV     = 24
) (
  input  logic              rc_clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              tune_run,
  input  logic              tune_upd,
  input  logic              use_prog,
  input  logic              step_flip,
  input  logic [CODE_W-1:0] prog_code,
  input  logic [HYS_W-1:0]  hyst_hi,
  input  logic [HYS_W-1:0]  hyst_lo,
  input  logic [CNT_W-1:0]  target_cnt,
  input  logic              mhz_en,
  input  logic              mhz_sel,
  input  logic [CNT_W-1:0]  mhz_target,
  input  logic              err_clr,
  output logic [CODE_W-1:0] code_now,
  output logic [CNT_W-1:0]  cnt_last,
  output logic              mhz_clk,
  output logic              mhz_err
);
  logic              win_edge;
  logic              meas_vld;
  logic [CNT_W-1:0]  meas_cnt;
  logic [CODE_W-1:0] calc_code;

  rc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(rc_clk), .rst_n(rst_n), .ref_in(ref_clk), .edge_o(win_edge)
  );

  rc_window_counter #(.CNT_W(CNT_W)) u_win (
    .clk(rc_clk), .rst_n(rst_n), .run(tune_run), .edge_i(win_edge),
    .meas_cnt(meas_cnt), .meas_vld(meas_vld), .last_cnt(cnt_last)
  );

  rc_code_stepper #(.CODE_W(CODE_W), .CNT_W(CNT_W), .HYS_W(HYS_W)) u_step (
    .clk(rc_clk), .rst_n(rst_n), .run(tune_run), .upd(tune_upd),
    .flip(step_flip), .prog(prog_code), .tgt(target_cnt), .hh(hyst_hi),
    .hl(hyst_lo), .meas_vld(meas_vld), .meas_cnt(meas_cnt), .calc(calc_code)
  );

  rc_mhz_div #(.CNT_W(CNT_W), .RAW_DIV(RAW_DIV)) u_mhz (
    .clk(rc_clk), .rst_n(rst_n), .edge_i(win_edge), .en(mhz_en),
    .sel(mhz_sel), .tgt(mhz_target), .err_clr(err_clr),
    .mhz_clk(mhz_clk), .err(mhz_err)
  );

  assign code_now = use_prog ? prog_code : calc_code;
endmodule

// File: tb/rc_trim_loop_tb.sv
module rc_trim_loop_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic        run = 1'b0, upd = 1'b1, byp = 1'b0, flip = 1'b0;
  logic [7:0]  prog = 8'h80;
  logic [3:0]  hh = 4'd2, hl = 4'd3;
  logic [11:0] tgt = 12'd100;
  logic        men = 1'b0, msel = 1'b1;
  logic [11:0] mtgt = 12'd10;
  logic        eclr = 1'b0;
  logic [7:0]  code_now;
  logic [11:0] cnt_last;
  logic        mhz_clk, mhz_err;

  int checks = 0, fails = 0;
  bit armed = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  rc_trim_loop u_dut (
    .rc_clk(clk), .rst_n(rst_n), .ref_clk(ref_in), .tune_run(run),
    .tune_upd(upd), .use_prog(byp), .step_flip(flip), .prog_code(prog),
    .hyst_hi(hh), .hyst_lo(hl), .target_cnt(tgt), .mhz_en(men),
    .mhz_sel(msel), .mhz_target(mtgt), .err_clr(eclr), .code_now(code_now),
    .cnt_last(cnt_last), .mhz_clk(mhz_clk), .mhz_err(mhz_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_q[$] = '{0, 0, 0};
  int m_win = 0, m_last = 0, m_calc = 0, m_div = 0, m_err = 0;
  bit m_primed = 0, m_hit = 0, m_seen = 0;

  function automatic int ratio();
    if (!msel) return 24;
    return (mtgt < 2) ? 2 : int'(mtgt);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = '{0, 0, 0}; m_win = 0; m_last = 0; m_calc = 0;
      m_div = 0; m_err = 0; m_primed = 0; m_hit = 0; m_seen = 0;
    end else begin
      bit e;
      int n;
      e = (m_q[1] == 1) && (m_q[2] == 0);
      m_q.push_front(int'(ref_in));
      void'(m_q.pop_back());
      n = ratio();
      if (!run) begin
        m_win = 0; m_primed = 0; m_calc = int'(prog);
      end else if (e) begin
        if (m_primed) begin
          int d, s;
          m_last = m_win;
          d = m_win - int'(tgt);
          s = 0;
          if (d > int'(hh)) s = -1;
          else if (-d > int'(hl)) s = 1;
          if (flip) s = -s;
          if (upd) m_calc = (m_calc + s > 255) ? 255 : (m_calc + s < 0) ? 0 : m_calc + s;
        end
        m_primed = 1; m_win = 1;
      end else if (m_win < 4095) m_win++;
      if (e) begin
        if (m_seen && men && !m_hit) m_err = 1;
        else if (eclr) m_err = 0;
        m_div = 0; m_hit = 0; m_seen = 1;
      end else begin
        if (eclr) m_err = 0;
        if (m_div >= n - 1) begin m_div = 0; m_hit = 1; end
        else m_div++;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(tag, "code_now", int'(code_now), byp ? int'(prog) : m_calc);
      chk(tag, "cnt_last", int'(cnt_last), m_last);
      chk(tag, "mhz_err", int'(mhz_err), m_err);
      chk(tag, "mhz_clk", int'(mhz_clk), int'(men && (m_div < ratio() / 2)));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  task automatic window(input int p);
    ref_in = 1'b1; step(2); ref_in = 1'b0; step(p - 2);
  endtask

  task automatic window_sample(input int p, output int highs);
    highs = 0;
    ref_in = 1'b1; step(2); ref_in = 1'b0; step(10);
    for (int i = 0; i < 40; i++) begin step(1); highs += int'(mhz_clk); end
    step(p - 52);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    int h;
    step(4);
    #1;
    chk("R1", "code_now", int'(code_now), 0);
    chk("R1", "cnt_last", int'(cnt_last), 0);
    chk("R1", "mhz_err", int'(mhz_err), 0);
    chk("R1", "mhz_clk", int'(mhz_clk), 0);
    armed = 1;
    rst_n = 1'b1;
    tag = "R5"; step(3); #1;
    chk("R5", "load prog while stopped", int'(code_now), 8'h80);
    // R2 R3: fast oscillator steps down, then band edges
    run = 1'b1; tag = "R3";
    window(110); window(110); window(110); #1;
    chk("R2", "window count", int'(cnt_last), 110);
    chk("R3", "down steps", int'(code_now), 8'h7E);
    window(102); window(97); window(96); window(100); #1;
    chk("R3", "band edges then up", int'(code_now), 8'h7E);
    chk("R2", "count 96", int'(cnt_last), 96);
    // R3 inverted stepping
    flip = 1'b1;
    window(110); window(110); window(50); #1;
    chk("R3", "flip reverses", int'(code_now), 8'h80);
    // R4 upper saturation, R5 stop and reload
    flip = 1'b0; run = 1'b0; prog = 8'hFE; tag = "R4";
    step(3); #1;
    chk("R5", "reload 0xFE", int'(code_now), 8'hFE);
    chk("R5", "count held", int'(cnt_last), 110);
    run = 1'b1;
    window(50); window(50); window(50); window(50); #1;
    chk("R4", "saturate 0xFF", int'(code_now), 8'hFF);
    run = 1'b0; prog = 8'h01; step(3);
    run = 1'b1;
    window(200); window(200); window(200); #1;
    chk("R4", "saturate 0x00", int'(code_now), 8'h00);
    // R6 update disabled
    run = 1'b0; prog = 8'h40; step(3);
    run = 1'b1; upd = 1'b0; tag = "R6";
    window(200); window(200); window(150); window(60); #1;
    chk("R6", "code held", int'(code_now), 8'h40);
    chk("R6", "count still updates", int'(cnt_last), 150);
    // R7 bypass
    upd = 1'b1; byp = 1'b1; tag = "R7";
    window(200); window(200); window(200); #1;
    chk("R7", "bypass drives prog", int'(code_now), 8'h40);
    prog = 8'h22; step(1); #1;
    chk("R7", "bypass follows prog", int'(code_now), 8'h22);
    byp = 1'b0; step(1); #1;
    chk("R7", "loop tracked underneath", int'(code_now), 8'h3F);
    // R8 derived clock
    men = 1'b1; msel = 1'b1; mtgt = 12'd10; tag = "R8";
    window_sample(100, h);
    chk("R8", "ratio 10 duty", h, 20);
    mtgt = 12'd1;
    window_sample(100, h);
    chk("R8", "ratio clamped to 2", h, 20);
    // R9 error flag on fixed ratio
    msel = 1'b0; tag = "R9";
    window(30); window(30); #1;
    chk("R9", "no error for long windows", int'(mhz_err), 0);
    window(20); window(30); #1;
    chk("R9", "error on short window", int'(mhz_err), 1);
    window(30); #1;
    chk("R9", "error sticky", int'(mhz_err), 1);
    eclr = 1'b1; step(1); eclr = 1'b0; #1;
    chk("R9", "error cleared", int'(mhz_err), 0);
    men = 1'b0; tag = "R8";
    window_sample(100, h);
    chk("R8", "disabled clock low", h, 0);
    window(20); window(20); #1;
    chk("R9", "no error when disabled", int'(mhz_err), 0);
    // R2 count saturation
    tag = "R2";
    window(4200); window(50); #1;
    chk("R2", "count saturates", int'(cnt_last), 4095);
    step(2);
    $display("  Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule